// File: doc/BRIEF.md
# User-Mode FPU Register-Mode Control

This unit keeps two pieces of privileged state for a 32-bit core: a configuration register (number 16, select 5 in the system-control space) that holds a user permission bit, and the floating-point register-mode bit of the status word. A read-only capability flag, set at reset, records whether user code may switch that mode at all. The unit receives decoded control-register moves, one request per cycle. It answers reads in the same cycle and applies writes at the next clock edge.

A switch of the register mode from user code needs two things: the hardware capability and the software permission. A request that has the capability but lacks the permission raises a reserved-instruction exception. When the capability is absent, every write to the configuration register has its permission bit forced to zero. Stores to the ordinary floating-point control registers pass straight through to the FPU. Any move that matches no rule raises an unpredictable-operation flag and changes no state.

Top module: `fr_mode_ctrl`

## Requirements
- R1: After reset the configuration register is zero, the mode bit `status_fr` is 0, and `cap_ufrp` equals the `HAS_UFR_SWITCH` parameter. It never changes after that.
- R2: A move from system control (`req_op`=1) with `req_reg`=16 and `req_sel`=5 raises `rd_valid` in the same cycle, with `rd_data` equal to the configuration register. A move to it (`req_op`=2, same address) is seen by a read in the next cycle.
- R3: With the capability set, a write stores all 32 bits of `req_wdata`. With the capability clear, bit 2 (the permission bit) is stored as 0 and every other bit is stored as given.
- R4: A control read from the FPU (`req_op`=3) of register 1, with both the capability and the permission set, gives `rd_valid`=1. Its `rd_data` has bit 0 equal to the mode bit and all other bits zero.
- R5: The same read with the capability set but the permission clear pulses `ri_exc` and leaves `rd_valid` low.
- R6: A control write to the FPU (`req_op`=4) with `req_rt`=0 clears the mode bit for register 1 and sets it for register 4. This needs both the capability and the permission. A read issued in the next cycle sees the new value.
- R7: Either switch form with the permission clear (and the capability set) pulses `ri_exc` and leaves the mode bit unchanged.
- R8: A control write to the FPU for register 25, 26, 28 or 31 raises `fcr_wr_en` in the same cycle and passes the index and data through unchanged.
- R9: A control write or read from the FPU that matches no rule raises `unpred` and changes no state. A control read of register 0, 25, 26, 28 or 31 is left to the FPU and raises nothing here.
- R10: `ri_exc`, `unpred`, `rd_valid` and `fcr_wr_en` are never high together. `ri_exc` lasts only for the cycle of its request.
- R11: With `req_valid` low, or with `req_op`=0, no output strobe rises and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Move class: 0 none, 1 read system ctrl, 2 write system ctrl, 3 read FPU ctrl, 4 write FPU ctrl |
| req_reg | input | 5 | Register number |
| req_sel | input | 3 | Select field of system-control moves |
| req_rt | input | 5 | General-register index of the source operand |
| req_wdata | input | 32 | Source operand value |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Read result |
| status_fr | output | 1 | Status floating-point register-mode bit |
| cap_ufrp | output | 1 | Capability flag for user-mode switching |
| ri_exc | output | 1 | Reserved-instruction exception pulse |
| unpred | output | 1 | Unpredictable-operation flag |
| fcr_wr_en | output | 1 | Forwarded FPU control store |
| fcr_wr_idx | output | 5 | Index of the forwarded store |
| fcr_wr_data | output | 32 | Data of the forwarded store |

## Verification
Two functions can meet at one clock edge. The first is a permission write or a mode switch. The second is a dependent request in the very next cycle, which must see the new state. The bench provokes this with back-to-back requests: it sets the permission and switches at once, then switches and reads at once. It judges each response against a reference model that steps one request per clock. A second instance built without the capability takes the same stimulus. It shows that the masked permission write and an exception-free, unpredictable switch request occur in the same cycles in which the capable instance grants them.

// File: rtl/fr_mode_pkg.sv
package fr_mode_pkg;

    typedef enum logic [2:0] {
        MV_NONE     = 3'd0,
        MV_FROM_SYS = 3'd1,
        MV_TO_SYS   = 3'd2,
        MV_FROM_FPU = 3'd3,
        MV_TO_FPU   = 3'd4
    } mv_op_e;

    // Action set that the decoder produces for one request
    typedef struct packed {
        logic cfg_rd;
        logic cfg_wr;
        logic fr_rd;
        logic fr_clr;
        logic fr_set;
        logic fcr_fwd;
        logic need_perm;
        logic unpred;
    } mv_act_t;

    function automatic logic is_fcr_store(input logic [4:0] idx);
        return (idx == 5'd25) || (idx == 5'd26) || (idx == 5'd28) || (idx == 5'd31);
    endfunction

    function automatic logic is_fcr_load(input logic [4:0] idx);
        return is_fcr_store(idx) || (idx == 5'd0);
    endfunction

endpackage

// File: rtl/fr_req_decode.sv
module fr_req_decode
    import fr_mode_pkg::*;
#(
    parameter int CFG_REG  = 16,
    parameter int CFG_SEL  = 5,
    parameter int CLR_REG  = 1,
    parameter int SET_REG  = 4,
    parameter int MODE_REG = 1
) (
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic [4:0]    reg_idx,
    input  logic [2:0]    sel,
    input  logic [4:0]    rt,
    input  logic          cap,
    output mv_act_t       act
);
    localparam logic [4:0] CfgReg  = 5'(CFG_REG);
    localparam logic [2:0] CfgSel  = 3'(CFG_SEL);
    localparam logic [4:0] ClrReg  = 5'(CLR_REG);
    localparam logic [4:0] SetReg  = 5'(SET_REG);
    localparam logic [4:0] ModeReg = 5'(MODE_REG);

    logic cfg_hit;
    logic switch_form;

    assign cfg_hit     = (reg_idx == CfgReg) && (sel == CfgSel);
    assign switch_form = ((reg_idx == ClrReg) || (reg_idx == SetReg)) && (rt == 5'd0) && cap;

    always_comb begin
        act = '0;
        if (valid) begin
            case (mv_op_e'(op))
                MV_FROM_SYS: act.cfg_rd = cfg_hit;
                MV_TO_SYS:   act.cfg_wr = cfg_hit;
                MV_FROM_FPU: begin
                    if (reg_idx == ModeReg && cap) begin
                        act.fr_rd     = 1'b1;
                        act.need_perm = 1'b1;
                    end else if (!is_fcr_load(reg_idx)) begin
                        act.unpred = 1'b1;
                    end
                end
                MV_TO_FPU: begin
                    if (is_fcr_store(reg_idx)) begin
                        act.fcr_fwd = 1'b1;
                    end else if (switch_form) begin
                        act.fr_clr    = (reg_idx == ClrReg);
                        act.fr_set    = (reg_idx == SetReg);
                        act.need_perm = 1'b1;
                    end else begin
                        act.unpred = 1'b1;
                    end
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/fr_cfg_wmask.sv
module fr_cfg_wmask #(
    parameter int XLEN    = 32,
    parameter int UFR_BIT = 2
) (
    input  logic            cap,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] wval
);
    localparam logic [XLEN-1:0] PermMask = XLEN'(1) << UFR_BIT;

    assign wval = cap ? wdata : (wdata & ~PermMask);

endmodule

// File: rtl/fr_rd_mux.sv
module fr_rd_mux #(
    parameter int XLEN = 32
) (
    input  logic            cfg_rd,
    input  logic            fr_rd,
    input  logic [XLEN-1:0] cfg_val,
    input  logic            fr_val,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_data
);
    always_comb begin
        rd_valid = cfg_rd | fr_rd;
        rd_data  = '0;
        if (cfg_rd) begin
            rd_data = cfg_val;
        end else if (fr_rd) begin
            rd_data = {{(XLEN-1){1'b0}}, fr_val};
        end
    end

endmodule

// File: rtl/fr_mode_ctrl.sv
module fr_mode_ctrl
    import fr_mode_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter int UFR_BIT        = 2,
    parameter int CFG_REG        = 16,
    parameter int CFG_SEL        = 5,
    parameter int HAS_UFR_SWITCH = 1,
    parameter int FR_RESET       = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [4:0]      req_reg,
    input  logic [2:0]      req_sel,
    input  logic [4:0]      req_rt,
    input  logic [XLEN-1:0] req_wdata,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_data,
    output logic            status_fr,
    output logic            cap_ufrp,
    output logic            ri_exc,
    output logic            unpred,
    output logic            fcr_wr_en,
    output logic [4:0]      fcr_wr_idx,
    output logic [XLEN-1:0] fcr_wr_data
);
    typedef struct packed {
        logic [XLEN-1:0] cfg5;
        logic            fr;
        logic            cap;
    } st_t;

    st_t             st_d, st_q;
    mv_act_t         act;
    logic [XLEN-1:0] cfg_wval;
    logic [XLEN-1:0] cfg5_q;
    logic            perm;
    logic            exc;

    fr_req_decode #(
        .CFG_REG (CFG_REG),
        .CFG_SEL (CFG_SEL)
    ) u_dec (
        .valid   (req_valid),
        .op      (req_op),
        .reg_idx (req_reg),
        .sel     (req_sel),
        .rt      (req_rt),
        .cap     (st_q.cap),
        .act     (act)
    );

    fr_cfg_wmask #(
        .XLEN    (XLEN),
        .UFR_BIT (UFR_BIT)
    ) u_wmask (
        .cap   (st_q.cap),
        .wdata (req_wdata),
        .wval  (cfg_wval)
    );

    fr_rd_mux #(
        .XLEN (XLEN)
    ) u_rd (
        .cfg_rd   (act.cfg_rd),
        .fr_rd    (act.fr_rd & perm),
        .cfg_val  (st_q.cfg5),
        .fr_val   (st_q.fr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign perm = st_q.cfg5[UFR_BIT];
    assign exc  = act.need_perm & ~perm;

    always_comb begin
        st_d = st_q;
        if (!exc) begin
            if (act.cfg_wr) st_d.cfg5 = cfg_wval;
            if (act.fr_clr) st_d.fr   = 1'b0;
            if (act.fr_set) st_d.fr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg5 <= '0;
            st_q.fr   <= 1'(FR_RESET);
            st_q.cap  <= 1'(HAS_UFR_SWITCH);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg5_q      = st_q.cfg5;
    assign status_fr   = st_q.fr;
    assign cap_ufrp    = st_q.cap;
    assign ri_exc      = exc;
    assign unpred      = act.unpred;
    assign fcr_wr_en   = act.fcr_fwd;
    assign fcr_wr_idx  = req_reg;
    assign fcr_wr_data = req_wdata;

endmodule

// File: rtl/fr_mode_chk.sv
module fr_mode_chk #(
    parameter int XLEN    = 32,
    parameter int UFR_BIT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic            rd_valid,
    input logic [XLEN-1:0] rd_data,
    input logic            status_fr,
    input logic            cap_ufrp,
    input logic            ri_exc,
    input logic            unpred,
    input logic            fcr_wr_en,
    input logic [XLEN-1:0] cfg5_q
);
    assert_cap_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cap_ufrp));

    assert_perm_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ufrp |-> !cfg5_q[UFR_BIT]);

    assert_fr_read_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && req_op == 3'd3) |-> (rd_data[XLEN-1:1] == '0 && rd_data[0] == status_fr));

    assert_fr_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_fr) |-> $past(req_valid && req_op == 3'd4));

    assert_exc_holds_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ri_exc |=> ($stable(status_fr) && $stable(cfg5_q)));

    assert_unpred_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |=> ($stable(status_fr) && $stable(cfg5_q)));

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ri_exc, unpred, rd_valid, fcr_wr_en}));

    assert_exc_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ri_exc |-> req_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(ri_exc || unpred || rd_valid || fcr_wr_en));

endmodule

bind fr_mode_ctrl fr_mode_chk #(
    .XLEN    (XLEN),
    .UFR_BIT (UFR_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .status_fr (status_fr),
    .cap_ufrp  (cap_ufrp),
    .ri_exc    (ri_exc),
    .unpred    (unpred),
    .fcr_wr_en (fcr_wr_en),
    .cfg5_q    (cfg5_q)
);

// File: tb/sim_fr_mode_ctrl.sv
module sim_fr_mode_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [4:0]  req_reg = '0;
    logic [2:0]  req_sel = '0;
    logic [4:0]  req_rt = '0;
    logic [31:0] req_wdata = '0;

    logic        rdv [2];
    logic [31:0] rdd [2];
    logic        fr  [2];
    logic        cap [2];
    logic        ri  [2];
    logic        un  [2];
    logic        fwe [2];
    logic [4:0]  fwi [2];
    logic [31:0] fwd [2];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state: index 0 capable, index 1 without capability
    logic [31:0] m_cfg [2];
    logic        m_fr  [2];
    logic        m_cap [2];

    always #(CLK_P/2) clk = ~clk;

    fr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_reg(req_reg), .req_sel(req_sel), .req_rt(req_rt), .req_wdata(req_wdata),
        .rd_valid(rdv[0]), .rd_data(rdd[0]), .status_fr(fr[0]), .cap_ufrp(cap[0]),
        .ri_exc(ri[0]), .unpred(un[0]), .fcr_wr_en(fwe[0]), .fcr_wr_idx(fwi[0]),
        .fcr_wr_data(fwd[0])
    );

    fr_mode_ctrl #(.HAS_UFR_SWITCH(0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_reg(req_reg), .req_sel(req_sel), .req_rt(req_rt), .req_wdata(req_wdata),
        .rd_valid(rdv[1]), .rd_data(rdd[1]), .status_fr(fr[1]), .cap_ufrp(cap[1]),
        .ri_exc(ri[1]), .unpred(un[1]), .fcr_wr_en(fwe[1]), .fcr_wr_idx(fwi[1]),
        .fcr_wr_data(fwd[1])
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit store_reg(input logic [4:0] r);
        return r == 25 || r == 26 || r == 28 || r == 31;
    endfunction

    task automatic step(input bit v, input logic [2:0] op, input logic [4:0] r,
                        input logic [2:0] s, input logic [4:0] rt, input logic [31:0] d);
        logic [31:0] n_cfg [2];
        logic        n_fr  [2];
        @(negedge clk);
        req_valid = v; req_op = op; req_reg = r; req_sel = s; req_rt = rt; req_wdata = d;
        #(CLK_P/4);
        for (int i = 0; i < 2; i++) begin
            bit e_rdv = 0, e_ri = 0, e_un = 0, e_fw = 0;
            logic [31:0] e_rdd = '0;
            string tag = "R11";
            n_cfg[i] = m_cfg[i];
            n_fr[i]  = m_fr[i];
            chk(fr[i] === m_fr[i], "R6", $sformatf("u%0d mode bit", i), 32'(fr[i]), 32'(m_fr[i]));
            if (v) begin
                if (op == 1 && r == 16 && s == 5) begin
                    tag = "R2"; e_rdv = 1; e_rdd = m_cfg[i];
                end else if (op == 2 && r == 16 && s == 5) begin
                    tag = "R3"; n_cfg[i] = m_cap[i] ? d : (d & 32'hFFFF_FFFB);
                end else if (op == 3) begin
                    if (r == 1 && m_cap[i]) begin
                        if (m_cfg[i][2]) begin tag = "R4"; e_rdv = 1; e_rdd = 32'(m_fr[i]); end
                        else begin tag = "R5"; e_ri = 1; end
                    end else if (!(store_reg(r) || r == 0)) begin
                        tag = "R9"; e_un = 1;
                    end else tag = "R9";
                end else if (op == 4) begin
                    if (store_reg(r)) begin
                        tag = "R8"; e_fw = 1;
                    end else if ((r == 1 || r == 4) && rt == 0 && m_cap[i]) begin
                        if (m_cfg[i][2]) begin tag = "R6"; n_fr[i] = (r == 4); end
                        else begin tag = "R7"; e_ri = 1; end
                    end else begin
                        tag = "R9"; e_un = 1;
                    end
                end
            end
            chk(rdv[i] === e_rdv, tag, $sformatf("u%0d rd_valid", i), 32'(rdv[i]), 32'(e_rdv));
            if (e_rdv) chk(rdd[i] === e_rdd, tag, $sformatf("u%0d rd_data", i), rdd[i], e_rdd);
            chk(ri[i] === e_ri, tag, $sformatf("u%0d ri_exc", i), 32'(ri[i]), 32'(e_ri));
            chk(un[i] === e_un, tag, $sformatf("u%0d unpred", i), 32'(un[i]), 32'(e_un));
            chk(fwe[i] === e_fw, tag, $sformatf("u%0d fcr_wr_en", i), 32'(fwe[i]), 32'(e_fw));
            if (e_fw) begin
                chk(fwi[i] === r, "R8", $sformatf("u%0d fcr idx", i), 32'(fwi[i]), 32'(r));
                chk(fwd[i] === d, "R8", $sformatf("u%0d fcr data", i), fwd[i], d);
            end
        end
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            m_cfg[i] = n_cfg[i];
            m_fr[i]  = n_fr[i];
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cap[0] = 1; m_cap[1] = 0;
        for (int i = 0; i < 2; i++) begin m_cfg[i] = '0; m_fr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(cap[0] === 1'b1, "R1", "u0 capability", 32'(cap[0]), 1);
        chk(cap[1] === 1'b0, "R1", "u1 capability", 32'(cap[1]), 0);
        chk(fr[0] === 1'b0 && fr[1] === 1'b0, "R1", "mode bits", {fr[0], fr[1]}, 0);
        step(1, 1, 16, 5, 0, 0);                  // R1/R2 config reads zero
        step(1, 2, 16, 5, 0, 32'hFFFF_FFFF);      // R3 full write vs masked
        step(1, 1, 16, 5, 0, 0);                  // R2 next-cycle visibility
        step(1, 2, 16, 5, 0, 32'h0000_0000);
        step(1, 3, 1, 0, 2, 0);                   // R5 read without permission
        step(1, 4, 4, 0, 0, 0);                   // R7 set without permission
        // read-modify-write of the permission bit
        step(1, 1, 16, 5, 0, 0);
        step(1, 2, 16, 5, 0, 32'h0000_0004 | 32'hA000_0000);
        step(1, 4, 1, 0, 0, 0);                   // R6 clear right after permission
        step(1, 3, 1, 0, 3, 0);                   // R4 reads 0
        step(1, 4, 4, 0, 0, 0);                   // R6 set
        step(1, 3, 1, 0, 3, 0);                   // R4 reads 1 next cycle
        step(1, 4, 4, 0, 7, 0);                   // R9 nonzero rt
        step(1, 4, 9, 0, 0, 0);                   // R9 unknown register
        step(1, 3, 7, 0, 0, 0);                   // R9 unknown read
        step(1, 3, 25, 0, 0, 0);                  // R9 standard read left alone
        step(1, 4, 25, 0, 4, 32'h1234_5678);      // R8
        step(1, 4, 31, 0, 4, 32'h0F0F_0000);      // R8
        step(0, 4, 1, 0, 0, 0);                   // R11 not valid
        step(1, 0, 1, 0, 0, 0);                   // R11 null op
        step(1, 1, 16, 0, 0, 0);                  // other select: nothing
        step(1, 4, 1, 0, 0, 0);                   // R6 clear
        step(1, 2, 16, 5, 0, 32'h0000_0010);      // drop permission
        step(1, 4, 4, 0, 0, 0);                   // R7 exception, bit stays
        step(1, 3, 1, 0, 1, 0);                   // R5
        step(0, 0, 0, 0, 0, 0);                   // R10 pulse gone
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule